// File: doc/BRIEF.md
# Interrupt Entry and Reset Sequencer

This block is the step controller at the top of a small 16-bit processor. It owns the program counter, the stack pointer and the status word. A step begins when `step_req` is seen in the idle state. At that moment the block samples the pending interrupt number and picks one of five outcomes:

- a reset;
- a vectored interrupt entry;
- an error for an out-of-range number;
- one instruction execution;
- an idle step when the processor is powered down.

An interrupt entry pushes the program counter and then the status word onto a descending stack through a write port. It then clears the enable and power-down bits, loads the program counter from a vector table and acknowledges the interrupt. The block does not execute instructions itself. It fetches the instruction word, tells an external executor what kind of instruction it is, and hands it over through a valid/done handshake. The executor returns the new register values, or an error, in which case the program counter goes back to the faulting instruction.

Memory reads are combinational. `mem_rdata` must answer `mem_raddr` within the same cycle.

Top module: `irqseq_top`

## Requirements
- R1: A pending number of 15 resets the step. The program counter takes the word read at address 0xFFFE, the stack pointer and status word become 0, and the step reports kind 0 with cost 0.
- R2: An interrupt is taken when one is pending and the enable bit (status bit 3) is set. Numbers 14 and 15 are acted on even when that bit is clear.
- R3: Entry writes the program counter to address SP-2, then in the next cycle writes the status word held before entry to SP-4, and leaves SP decreased by 4.
- R4: Entry clears status bits 3 and 4. It loads the program counter from the word at 0xFFE0 + 2·n, pulses `irq_ack` with `irq_ack_num` = n, and reports kind 1 with cost 6.
- R5: With no interrupt taken and the power-down bit (status bit 4) set, no instruction is fetched. The registers keep their values, and the step reports kind 3 with cost 1.
- R6: Otherwise the word at the program counter is fetched. `exec_insn` carries it, `exec_pc` carries its address plus 2, and `exec_valid` holds until `exec_done`. The executor's program counter, stack pointer and status word are then taken, and the step reports kind 2 with cost `exec_cycles`.
- R7: `exec_kind` is 0 (two-operand) when the opcode's top nibble is 4 or more, 1 (jump) when it is 2 or 3, and 2 (one-operand) when it is 0 or 1.
- R8: When `exec_done` comes with `exec_err`, the program counter returns to the fetched instruction's address. The stack pointer and status word are unchanged.
- R9: A pending number of 16 or more raises `irq_err` with `step_done`. It causes no entry, no write and no register change, and the step reports kind 4 with cost 0.
- R10: `step_req` and the interrupt inputs are ignored while a step is in progress. Within an entry, the latched number cannot change between the pushes, and no extra step follows.
- R11: After `rst_n` is asserted, all three registers read 0 and no output pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_req | input | 1 | Start a step (sampled in idle only) |
| irq_pend | input | 1 | An interrupt number is pending |
| irq_num | input | 5 | Pending interrupt number |
| mem_raddr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, same cycle |
| mem_we | output | 1 | Write strobe |
| mem_waddr | output | 16 | Write address |
| mem_wdata | output | 16 | Write data |
| exec_valid | output | 1 | Instruction handed to executor |
| exec_insn | output | 16 | Fetched instruction word |
| exec_kind | output | 2 | Instruction class |
| exec_pc | output | 16 | Address after the instruction word |
| exec_done | input | 1 | Executor finished |
| exec_err | input | 1 | Executor failed |
| exec_pc_next | input | 16 | New program counter |
| exec_sp_next | input | 16 | New stack pointer |
| exec_sr_next | input | 16 | New status word |
| exec_cycles | input | 4 | Cycle cost of the instruction |
| irq_ack | output | 1 | Entry acknowledge pulse |
| irq_ack_num | output | 5 | Number acknowledged |
| irq_err | output | 1 | Out-of-range number |
| step_done | output | 1 | Step completed (one cycle) |
| step_kind | output | 3 | Outcome of the step |
| step_cost | output | 4 | Accounted cycles |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| sr | output | 16 | Status word |

## Verification
The assertions assume the executor pulses `exec_done` for one cycle, and only while `exec_valid` is high. They also assume `mem_rdata` is a stable function of `mem_raddr`. The bench models memory as a pure function of the address and answers each handshake exactly once, after a random delay of zero to three cycles.

Interrupt numbers and the status words the executor returns are drawn at random. This mixes enabled and disabled interrupts, powered-down steps and out-of-range numbers. A directed case raises `step_req` in the middle of an entry to check that the request is ignored.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  localparam int XW = 16;
  localparam int NW = 5;

  typedef enum logic [2:0] {
    ACT_RESET = 3'd0,
    ACT_ENTRY = 3'd1,
    ACT_EXEC  = 3'd2,
    ACT_SLEEP = 3'd3,
    ACT_BAD   = 3'd4
  } act_e;

  typedef enum logic [1:0] {
    IK_DOUBLE = 2'd0,
    IK_JUMP   = 2'd1,
    IK_SINGLE = 2'd2
  } ikind_e;

  function automatic ikind_e classify(input logic [XW-1:0] w);
    if (w[15:12] >= 4'd4)      return IK_DOUBLE;
    else if (w[15:12] >= 4'd2) return IK_JUMP;
    else                       return IK_SINGLE;
  endfunction

  function automatic logic [XW-1:0] vec_addr(input logic [XW-1:0] base,
                                             input logic [NW-1:0] n);
    return base + XW'({n, 1'b0});
  endfunction
endpackage

// File: rtl/irqseq_decide.sv
module irqseq_decide
  import irqseq_pkg::*;
#(
  parameter int GIE_BIT = 3,
  parameter int OFF_BIT = 4,
  parameter int RST_NUM = 15,
  parameter int NMI_MIN = 14,
  parameter int NUM_LIM = 16
) (
  input  logic          pend,
  input  logic [NW-1:0] num,
  input  logic [XW-1:0] sr,
  output act_e          act
);
  always_comb begin
    if (pend && num == NW'(RST_NUM))                          act = ACT_RESET;
    else if (pend && num >= NW'(NUM_LIM))                     act = ACT_BAD;
    else if (pend && (sr[GIE_BIT] || num >= NW'(NMI_MIN)))    act = ACT_ENTRY;
    else if (!sr[OFF_BIT])                                    act = ACT_EXEC;
    else                                                      act = ACT_SLEEP;
  end
endmodule

// File: rtl/irqseq_insn_class.sv
module irqseq_insn_class
  import irqseq_pkg::*;
(
  input  logic [XW-1:0] insn,
  output logic [1:0]    kind
);
  ikind_e k;
  always_comb k = classify(insn);
  assign kind = k;
endmodule

// File: rtl/irqseq_top.sv
module irqseq_top
  import irqseq_pkg::*;
#(
  parameter logic [15:0] RST_VEC    = 16'hFFFE,
  parameter logic [15:0] VEC_BASE   = 16'hFFE0,
  parameter int          GIE_BIT    = 3,
  parameter int          OFF_BIT    = 4,
  parameter int          ENTRY_COST = 6,
  parameter int          SLEEP_COST = 1,
  parameter int          CW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_req,
  input  logic          irq_pend,
  input  logic [4:0]    irq_num,
  output logic [15:0]   mem_raddr,
  input  logic [15:0]   mem_rdata,
  output logic          mem_we,
  output logic [15:0]   mem_waddr,
  output logic [15:0]   mem_wdata,
  output logic          exec_valid,
  output logic [15:0]   exec_insn,
  output logic [1:0]    exec_kind,
  output logic [15:0]   exec_pc,
  input  logic          exec_done,
  input  logic          exec_err,
  input  logic [15:0]   exec_pc_next,
  input  logic [15:0]   exec_sp_next,
  input  logic [15:0]   exec_sr_next,
  input  logic [CW-1:0] exec_cycles,
  output logic          irq_ack,
  output logic [4:0]    irq_ack_num,
  output logic          irq_err,
  output logic          step_done,
  output logic [2:0]    step_kind,
  output logic [CW-1:0] step_cost,
  output logic [15:0]   pc,
  output logic [15:0]   sp,
  output logic [15:0]   sr
);
  localparam logic [XW-1:0] WSTEP = XW'(2);
  localparam logic [XW-1:0] CLR_MASK = ~((XW'(1) << GIE_BIT) | (XW'(1) << OFF_BIT));

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_PUSH_PC, S_PUSH_SR, S_VEC, S_FETCH, S_EXEC, S_DONE
  } st_e;

  st_e             st;
  logic [XW-1:0]   pc_q, sp_q, sr_q, insn_q, iaddr_q;
  logic [NW-1:0]   irq_q;
  act_e            kind_q, act;
  logic [CW-1:0]   cost_q;

  // named internal events for the assertions
  logic ev_start, ev_push_pc, ev_push_sr, ev_vec, ev_exec_fin;
  assign ev_start    = (st == S_IDLE) && step_req;
  assign ev_push_pc  = (st == S_PUSH_PC);
  assign ev_push_sr  = (st == S_PUSH_SR);
  assign ev_vec      = (st == S_VEC);
  assign ev_exec_fin = (st == S_EXEC) && exec_done;

  irqseq_decide #(.GIE_BIT(GIE_BIT), .OFF_BIT(OFF_BIT)) u_decide (
    .pend (irq_pend),
    .num  (irq_num),
    .sr   (sr_q),
    .act  (act)
  );

  irqseq_insn_class u_class (
    .insn (insn_q),
    .kind (exec_kind)
  );

  always_comb begin
    case (st)
      S_RST:   mem_raddr = RST_VEC;
      S_VEC:   mem_raddr = vec_addr(VEC_BASE, irq_q);
      S_FETCH: mem_raddr = pc_q;
      default: mem_raddr = '0;
    endcase
  end

  assign mem_we      = ev_push_pc || ev_push_sr;
  assign mem_waddr   = sp_q - WSTEP;
  assign mem_wdata   = ev_push_pc ? pc_q : sr_q;
  assign exec_valid  = (st == S_EXEC);
  assign exec_insn   = insn_q;
  assign exec_pc     = pc_q;
  assign irq_ack     = ev_vec;
  assign irq_ack_num = irq_q;
  assign step_done   = (st == S_DONE);
  assign irq_err     = step_done && (kind_q == ACT_BAD);
  assign step_kind   = kind_q;
  assign step_cost   = cost_q;
  assign pc = pc_q;
  assign sp = sp_q;
  assign sr = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pc_q    <= '0;
      sp_q    <= '0;
      sr_q    <= '0;
      insn_q  <= '0;
      iaddr_q <= '0;
      irq_q   <= '0;
      kind_q  <= ACT_RESET;
      cost_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (step_req) begin
          irq_q  <= irq_num;
          kind_q <= act;
          cost_q <= '0;
          case (act)
            ACT_RESET: st <= S_RST;
            ACT_ENTRY: st <= S_PUSH_PC;
            ACT_EXEC:  st <= S_FETCH;
            ACT_SLEEP: begin cost_q <= CW'(SLEEP_COST); st <= S_DONE; end
            default:   st <= S_DONE;
          endcase
        end
        S_RST: begin
          pc_q <= mem_rdata;
          sp_q <= '0;
          sr_q <= '0;
          st   <= S_DONE;
        end
        S_PUSH_PC: begin sp_q <= sp_q - WSTEP; st <= S_PUSH_SR; end
        S_PUSH_SR: begin sp_q <= sp_q - WSTEP; st <= S_VEC; end
        S_VEC: begin
          pc_q   <= mem_rdata;
          sr_q   <= sr_q & CLR_MASK;
          cost_q <= CW'(ENTRY_COST);
          st     <= S_DONE;
        end
        S_FETCH: begin
          insn_q  <= mem_rdata;
          iaddr_q <= pc_q;
          pc_q    <= pc_q + WSTEP;
          st      <= S_EXEC;
        end
        S_EXEC: if (exec_done) begin
          cost_q <= exec_cycles;
          if (exec_err) begin
            pc_q <= iaddr_q;
          end else begin
            pc_q <= exec_pc_next;
            sp_q <= exec_sp_next;
            sr_q <= exec_sr_next;
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && kind_q == ACT_RESET) |-> (sr_q == '0 && sp_q == '0)); // R1
  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_pc |=> (mem_we && mem_waddr == $past(mem_waddr) - WSTEP)); // R3
  AST_ACK_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (step_done && !sr_q[GIE_BIT] && !sr_q[OFF_BIT])); // R4
  AST_SLEEP_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && kind_q == ACT_SLEEP) |-> (pc_q == $past(pc_q))); // R5
  AST_ERR_RESTORES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_exec_fin && exec_err) |=> (pc_q == $past(iaddr_q))); // R8
  AST_BAD_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (step_done && !irq_ack && !mem_we)); // R9
  AST_IRQ_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_sr |-> $stable(irq_q)); // R10
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, mem_we, exec_valid, irq_ack, step_done})); // R10
endmodule

// File: tb/irqseq_top_tb.sv
module irqseq_top_tb;
  logic clk = 0, rst_n = 0;
  logic step_req = 0, irq_pend = 0;
  logic [4:0] irq_num = 0;
  logic [15:0] mem_raddr, mem_rdata, mem_waddr, mem_wdata;
  logic mem_we, exec_valid, irq_ack, irq_err, step_done;
  logic [15:0] exec_insn, exec_pc, pc, sp, sr;
  logic [1:0] exec_kind;
  logic exec_done = 0, exec_err = 0;
  logic [15:0] exec_pc_next = 0, exec_sp_next = 0, exec_sr_next = 0;
  logic [3:0] exec_cycles = 0, step_cost;
  logic [4:0] irq_ack_num;
  logic [2:0] step_kind;

  int nchk = 0, nbad = 0;
  logic [15:0] m_pc = 0, m_sp = 0, m_sr = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mrd(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3A5;
  endfunction
  assign mem_rdata = mrd(mem_raddr);

  irqseq_top u_dut (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_step(input bit pend, input logic [4:0] num,
                         input logic [15:0] npc, input logic [15:0] nsp,
                         input logic [15:0] nsr, input bit nerr,
                         input logic [3:0] ncyc, input int dly, input bit poke);
    int e_kind, e_cost, wcnt, acks, dcnt, cyc;
    bit done, resp;
    logic [15:0] wa[2], wd[2];
    logic [4:0] anum;
    logic [15:0] e_insn;
    logic [1:0] e_ik;
    logic [15:0] o_pc, o_sp, o_sr;
    o_pc = m_pc; o_sp = m_sp; o_sr = m_sr;
    if (pend && num == 5'd15) e_kind = 0;
    else if (pend && num >= 5'd16) e_kind = 4;
    else if (pend && (m_sr[3] || num >= 5'd14)) e_kind = 1;
    else if (!m_sr[4]) e_kind = 2;
    else e_kind = 3;
    e_insn = mrd(m_pc);
    e_ik = (e_insn[15:12] >= 4) ? 2'd0 : (e_insn[15:12] >= 2) ? 2'd1 : 2'd2;
    case (e_kind)
      0: begin m_pc = mrd(16'hFFFE); m_sp = 0; m_sr = 0; e_cost = 0; end
      1: begin m_pc = mrd(16'hFFE0 + {10'd0, num, 1'b0}); m_sp = o_sp - 4;
               m_sr = o_sr & ~16'h0018; e_cost = 6; end
      2: begin
        e_cost = ncyc;
        if (nerr) m_pc = o_pc;
        else begin m_pc = npc; m_sp = nsp; m_sr = nsr; end
      end
      3: e_cost = 1;
      default: e_cost = 0;
    endcase
    @(negedge clk);
    step_req = 1; irq_pend = pend; irq_num = num;
    @(negedge clk);
    step_req = 0; irq_pend = $urandom; irq_num = 5'($urandom);
    wcnt = 0; acks = 0; dcnt = 0; cyc = 0; done = 0; resp = 0; anum = 0;
    while (!done && cyc < 60) begin
      if (step_req) step_req = 0;
      if (mem_we) begin
        if (wcnt < 2) begin wa[wcnt] = mem_waddr; wd[wcnt] = mem_wdata; end
        wcnt++;
        if (poke && wcnt == 1) begin step_req = 1; irq_pend = 1; irq_num = 5'd15; end
      end
      if (irq_ack) begin acks++; anum = irq_ack_num; end
      if (exec_valid && !resp) begin
        if (dcnt == dly) begin
          chk("R6 insn", exec_insn, e_insn);
          chk("R6 pc+2", exec_pc, o_pc + 16'd2);
          chk("R7 kind", exec_kind, e_ik);
          exec_done = 1; exec_err = nerr; exec_pc_next = npc;
          exec_sp_next = nsp; exec_sr_next = nsr; exec_cycles = ncyc;
          resp = 1;
        end else dcnt++;
      end
      if (step_done) begin
        done = 1;
        chk("R1/R2/R5/R6/R9 kind", step_kind, e_kind);
        chk("R4/R5/R6 cost", step_cost, e_cost);
        chk("R9 irq_err", irq_err, e_kind == 4);
        chk(nerr && e_kind == 2 ? "R8 pc" : "R1/R4/R6 pc", pc, m_pc);
        chk("R3/R6 sp", sp, m_sp);
        chk("R4/R6 sr", sr, m_sr);
      end
      @(negedge clk);
      exec_done = 0;
      cyc++;
    end
    if (!done) chk("watchdog", 0, 1);
    chk("R3/R9 write count", wcnt, e_kind == 1 ? 2 : 0);
    chk("R4 ack count", acks, e_kind == 1 ? 1 : 0);
    if (e_kind == 1) begin
      chk("R3 push pc addr", wa[0], o_sp - 16'd2);
      chk("R3 push pc data", wd[0], o_pc);
      chk("R3 push sr addr", wa[1], o_sp - 16'd4);
      chk("R3 push sr data", wd[1], o_sr);
      chk("R4 ack num", anum, num);
    end
    if (poke) begin
      step_req = 0;
      for (int i = 0; i < 3; i++) begin
        chk("R10 no extra step", step_done, 0);
        chk("R10 pc kept", pc, m_pc);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #20;
    chk("R11 pc", pc, 0); chk("R11 sp", sp, 0); chk("R11 sr", sr, 0);
    chk("R11 done", step_done, 0); chk("R11 we", mem_we, 0);
    chk("R11 ack", irq_ack, 0);
    @(negedge clk); rst_n = 1;
    // directed corners
    do_step(0, 0, 16'h1000, 16'h0400, 16'h0000, 0, 4'd3, 0, 0);  // R6 plain exec
    do_step(1, 5'd5, 16'h2000, 16'h0400, 16'h0010, 0, 4'd2, 2, 0); // R2 disabled irq -> exec
    do_step(1, 5'd5, 0, 0, 0, 0, 4'd1, 0, 0);                     // R5 sleep
    do_step(1, 5'd14, 0, 0, 0, 0, 4'd1, 0, 0);                    // R2 14 ignores enable, wakes
    do_step(1, 5'd20, 0, 0, 0, 0, 4'd1, 0, 0);                    // R9 out of range
    do_step(0, 0, 16'h3000, 16'h0300, 16'h0008, 0, 4'd5, 1, 0);  // set enable
    do_step(1, 5'd3, 0, 0, 0, 0, 4'd1, 0, 1);                     // R3 R4 R10 entry with poke
    do_step(0, 0, 16'h5555, 16'h1111, 16'h0008, 1, 4'd7, 3, 0);  // R8 exec error
    do_step(1, 5'd15, 0, 0, 0, 0, 4'd1, 0, 0);                    // R1 reset
    do_step(1, 5'd31, 0, 0, 0, 0, 4'd1, 0, 0);                    // R9 max number
    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [4:0] n;
      int sel;
      sel = $urandom_range(0, 9);
      n = (sel < 6) ? 5'($urandom_range(0, 13)) : (sel < 8) ? 5'($urandom_range(14, 15))
                                                 : 5'($urandom_range(16, 31));
      do_step($urandom_range(0, 2) != 0 ? (sel >= 6 ? 1'b1 : 1'($urandom)) : 1'b0, n,
              16'($urandom) & 16'hFFFE, 16'($urandom) & 16'hFFFE,
              16'($urandom) & 16'h01FF, ($urandom_range(0, 7) == 0),
              4'($urandom_range(1, 15)), $urandom_range(0, 3), 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #900000;
    nchk++; nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule